// File: doc/BRIEF.md
# Programmable Raster Strobe Generator

This block produces the frame timing for an image sensor's digital video port. It runs a horizontal clock counter and a vertical line counter, both advanced by a pixel-clock enable. From the two counters it decodes three strobes. A frame-sync strobe marks the first line of every frame. A frame-window strobe covers the lines that carry picture data. A line-window strobe covers the clocks of those lines that carry picture bytes.

There are two raster formats: a full-resolution format and a quarter-resolution format. Both are 300 lines high. A line lasts 1000 clocks in full resolution and 500 clocks in quarter resolution. The active window is set by four 8-bit inputs, each in a scaled encoding. The mode and the window are copied into a shadow copy only at a frame boundary or on a synchronous timing restart, so a change never tears a frame that is in progress. Each strobe has its own polarity input.

Top module: `vid_timing_gen`

## Requirements
- R1: After reset both counters are 0 and the window uses built-in defaults: full-resolution mode, horizontal start 14, width code 176, vertical start 8, line code 160.
- R2: The horizontal counter rises by one on each cycle with `pix_en` high. It wraps to 0 after 1000 clocks in full mode and after 500 clocks in quarter mode (`qtr_mode` = 1). At each wrap the vertical counter rises by one, and it wraps to 0 after 300 lines. With `pix_en` low both counters hold.
- R3: When `tmg_restart` is high at a clock edge, both counters are 0 after that edge, whatever `pix_en` is, and the current mode and window inputs are taken into the shadow copy.
- R4: The frame-window strobe is active on lines v with vstart <= v < vstart + L. L is line code + 128 in full mode and (line code + 128) / 2, rounded down, in quarter mode.
- R5: The line-window strobe is active when the frame-window strobe is active and the horizontal count h satisfies hstart <= h < hstart + W. W is width code x 4 clocks in full mode (two bytes per pixel) and width code x 2 clocks in quarter mode.
- R6: The frame-sync strobe is active during the whole of line 0 of every frame and at no other time.
- R7: A polarity input of 0 makes its strobe active-high, and 1 makes it active-low. A polarity change acts on the output in the same cycle.
- R8: The window is clipped to the raster. The line window ends no later than the last clock of the line, and the frame window ends no later than the last line of the frame.
- R9: Changes to the mode or window inputs have no effect until the last clock of the frame has passed, or until a timing restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel clock enable; counters advance when high |
| tmg_restart | input | 1 | Synchronous restart to frame origin, also loads the shadow copy |
| qtr_mode | input | 1 | 0 full resolution, 1 quarter resolution |
| win_hstart | input | 8 | Line-window start, in clocks |
| win_hwidth | input | 8 | Width code, in units of 2 pixels |
| win_vstart | input | 8 | Frame-window start, in lines |
| win_vlines | input | 8 | Line code, active lines = code + 128 (halved in quarter mode) |
| pol_vd | input | 1 | Frame-sync polarity |
| pol_avf | input | 1 | Frame-window polarity |
| pol_avh | input | 1 | Line-window polarity |
| vd_o | output | 1 | Frame-sync strobe |
| avf_o | output | 1 | Frame-window strobe |
| avh_o | output | 1 | Line-window strobe |
| hcnt_o | output | 10 | Horizontal clock count |
| vcnt_o | output | 9 | Vertical line count |

## Verification
The assertions assume that `tmg_restart` and the configuration inputs are held steady around the clock edge, and that `pix_en` is a plain enable with no assumed pattern. The bench changes every input one time unit after a rising edge and samples on the falling edge. It uses both a steady enable and a gapped one. It shrinks the raster through parameters so that whole frames fit in the run. It picks window codes that land inside, across and beyond the raster edges, so that both clipping limits are reached.

// File: rtl/vid_timing_pkg.sv
package vid_timing_pkg;

  localparam int unsigned WIN_W = 16;

  typedef struct packed {
    logic       qtr;
    logic [7:0] hs;
    logic [7:0] hw;
    logic [7:0] vs;
    logic [7:0] vl;
  } win_cfg_t;

  // clocks covered by the line window before clipping
  function automatic logic [WIN_W-1:0] h_span(input logic [7:0] code, input logic qtr);
    logic [WIN_W-1:0] w;
    w = WIN_W'(code);
    return qtr ? (w << 1) : (w << 2);
  endfunction

  // lines covered by the frame window before clipping
  function automatic logic [WIN_W-1:0] v_span(input logic [7:0] code, input logic qtr);
    logic [WIN_W-1:0] n;
    n = WIN_W'(code) + WIN_W'(128);
    return qtr ? (n >> 1) : n;
  endfunction

  // exclusive end position, limited to the raster size
  function automatic logic [WIN_W-1:0] clip_end(input logic [WIN_W-1:0] start,
                                                input logic [WIN_W-1:0] span,
                                                input logic [WIN_W-1:0] limit);
    logic [WIN_W-1:0] e;
    e = start + span;
    return (e > limit) ? limit : e;
  endfunction

endpackage

// File: rtl/vtg_cfg_shadow.sv
module vtg_cfg_shadow
  import vid_timing_pkg::*;
#(
  parameter int unsigned DEF_HSTART = 14,
  parameter int unsigned DEF_HWIDTH = 176,
  parameter int unsigned DEF_VSTART = 8,
  parameter int unsigned DEF_VLINES = 160
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  win_cfg_t cfg_in,
  output win_cfg_t cfg_q
);

  localparam win_cfg_t CFG_RST = '{qtr: 1'b0,
                                   hs:  8'(DEF_HSTART),
                                   hw:  8'(DEF_HWIDTH),
                                   vs:  8'(DEF_VSTART),
                                   vl:  8'(DEF_VLINES)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= CFG_RST;
    else if (load) cfg_q <= cfg_in;
  end

endmodule

// File: rtl/vtg_raster_cnt.sv
module vtg_raster_cnt #(
  parameter int unsigned FULL_CLKS   = 1000,
  parameter int unsigned QTR_CLKS    = 500,
  parameter int unsigned FRAME_LINES = 300,
  parameter int unsigned HW          = 10,
  parameter int unsigned VW          = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic          restart,
  input  logic          qtr,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt,
  output logic          frame_wrap
);

  localparam logic [HW-1:0] H_LAST_FULL = HW'(FULL_CLKS - 1);
  localparam logic [HW-1:0] H_LAST_QTR  = HW'(QTR_CLKS - 1);
  localparam logic [VW-1:0] V_LAST      = VW'(FRAME_LINES - 1);

  logic [HW-1:0] h_last;
  logic          at_line_end;
  logic          at_frame_end;

  assign h_last       = qtr ? H_LAST_QTR : H_LAST_FULL;
  assign at_line_end  = (hcnt == h_last);
  assign at_frame_end = at_line_end && (vcnt == V_LAST);
  assign frame_wrap   = pix_en && !restart && at_frame_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (restart) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (pix_en) begin
      if (at_line_end) begin
        hcnt <= '0;
        vcnt <= (vcnt == V_LAST) ? '0 : vcnt + VW'(1);
      end else begin
        hcnt <= hcnt + HW'(1);
      end
    end
  end

endmodule

// File: rtl/vtg_strobe_dec.sv
module vtg_strobe_dec
  import vid_timing_pkg::*;
#(
  parameter int unsigned FULL_CLKS   = 1000,
  parameter int unsigned QTR_CLKS    = 500,
  parameter int unsigned FRAME_LINES = 300,
  parameter int unsigned HW          = 10,
  parameter int unsigned VW          = 9
) (
  input  logic [HW-1:0] hcnt,
  input  logic [VW-1:0] vcnt,
  input  win_cfg_t      cfg,
  output logic [2:0]    raw   // [0] line window, [1] frame window, [2] frame sync
);

  localparam logic [WIN_W-1:0] LINE_FULL = WIN_W'(FULL_CLKS);
  localparam logic [WIN_W-1:0] LINE_QTR  = WIN_W'(QTR_CLKS);
  localparam logic [WIN_W-1:0] FRAME_H   = WIN_W'(FRAME_LINES);

  logic [WIN_W-1:0] h_pos, v_pos;
  logic [WIN_W-1:0] h_beg, v_beg;
  logic [WIN_W-1:0] h_end, v_end;
  logic             in_rows, in_cols;

  always_comb begin
    h_pos   = WIN_W'(hcnt);
    v_pos   = WIN_W'(vcnt);
    h_beg   = WIN_W'(cfg.hs);
    v_beg   = WIN_W'(cfg.vs);
    h_end   = clip_end(h_beg, h_span(cfg.hw, cfg.qtr), cfg.qtr ? LINE_QTR : LINE_FULL);
    v_end   = clip_end(v_beg, v_span(cfg.vl, cfg.qtr), FRAME_H);
    in_rows = (v_pos >= v_beg) && (v_pos < v_end);
    in_cols = (h_pos >= h_beg) && (h_pos < h_end);
    raw[0]  = in_rows && in_cols;
    raw[1]  = in_rows;
    raw[2]  = (vcnt == '0);
  end

endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
  import vid_timing_pkg::*;
#(
  parameter int unsigned FULL_CLKS   = 1000,
  parameter int unsigned QTR_CLKS    = 500,
  parameter int unsigned FRAME_LINES = 300,
  parameter int unsigned DEF_HSTART  = 14,
  parameter int unsigned DEF_HWIDTH  = 176,
  parameter int unsigned DEF_VSTART  = 8,
  parameter int unsigned DEF_VLINES  = 160,
  localparam int unsigned HW         = $clog2(FULL_CLKS),
  localparam int unsigned VW         = $clog2(FRAME_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic          tmg_restart,
  input  logic          qtr_mode,
  input  logic [7:0]    win_hstart,
  input  logic [7:0]    win_hwidth,
  input  logic [7:0]    win_vstart,
  input  logic [7:0]    win_vlines,
  input  logic          pol_vd,
  input  logic          pol_avf,
  input  logic          pol_avh,
  output logic          vd_o,
  output logic          avf_o,
  output logic          avh_o,
  output logic [HW-1:0] hcnt_o,
  output logic [VW-1:0] vcnt_o
);

  win_cfg_t   cfg_in;
  win_cfg_t   sh_cfg;
  logic       frame_wrap;
  logic       shadow_load;
  logic [2:0] strobe_raw;
  logic [2:0] strobe_pol;
  logic [2:0] strobe_out;

  assign cfg_in      = '{qtr: qtr_mode, hs: win_hstart, hw: win_hwidth,
                         vs: win_vstart, vl: win_vlines};
  assign shadow_load = tmg_restart || frame_wrap;

  vtg_cfg_shadow #(
    .DEF_HSTART(DEF_HSTART), .DEF_HWIDTH(DEF_HWIDTH),
    .DEF_VSTART(DEF_VSTART), .DEF_VLINES(DEF_VLINES)
  ) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(shadow_load), .cfg_in(cfg_in), .cfg_q(sh_cfg)
  );

  vtg_raster_cnt #(
    .FULL_CLKS(FULL_CLKS), .QTR_CLKS(QTR_CLKS), .FRAME_LINES(FRAME_LINES),
    .HW(HW), .VW(VW)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .restart(tmg_restart),
    .qtr(sh_cfg.qtr), .hcnt(hcnt_o), .vcnt(vcnt_o), .frame_wrap(frame_wrap)
  );

  vtg_strobe_dec #(
    .FULL_CLKS(FULL_CLKS), .QTR_CLKS(QTR_CLKS), .FRAME_LINES(FRAME_LINES),
    .HW(HW), .VW(VW)
  ) u_dec (
    .hcnt(hcnt_o), .vcnt(vcnt_o), .cfg(sh_cfg), .raw(strobe_raw)
  );

  assign strobe_pol = {pol_vd, pol_avf, pol_avh};

  for (genvar i = 0; i < 3; i++) begin : g_pol
    assign strobe_out[i] = strobe_raw[i] ^ strobe_pol[i];
  end

  assign avh_o = strobe_out[0];
  assign avf_o = strobe_out[1];
  assign vd_o  = strobe_out[2];

endmodule

// File: rtl/vid_timing_gen_chk.sv
module vid_timing_gen_chk
  import vid_timing_pkg::*;
#(
  parameter int unsigned FULL_CLKS   = 1000,
  parameter int unsigned QTR_CLKS    = 500,
  parameter int unsigned FRAME_LINES = 300,
  parameter int unsigned HW          = 10,
  parameter int unsigned VW          = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_en,
  input logic          tmg_restart,
  input logic [HW-1:0] hcnt,
  input logic [VW-1:0] vcnt,
  input logic [2:0]    strobe_raw,
  input logic          frame_wrap,
  input logic          shadow_load,
  input win_cfg_t      sh_cfg,
  input win_cfg_t      cfg_in
);

  logic [HW-1:0] line_last;
  assign line_last = sh_cfg.qtr ? HW'(QTR_CLKS - 1) : HW'(FULL_CLKS - 1);

  a_r2_hcnt_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt <= line_last);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_en && !tmg_restart) |=> ($stable(hcnt) && $stable(vcnt)));

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && !tmg_restart && hcnt != line_last) |=> (hcnt == $past(hcnt) + HW'(1)));

  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tmg_restart |=> (hcnt == '0 && vcnt == '0 && sh_cfg == $past(cfg_in)));

  a_r4_avf_flat_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && !tmg_restart && hcnt != line_last) |=> $stable(strobe_raw[1]));

  a_r5_avh_in_avf: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_raw[0] |-> strobe_raw[1]);

  a_r6_vd_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> (strobe_raw[2] && hcnt == '0));

  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shadow_load |=> $stable(sh_cfg));

endmodule

bind vid_timing_gen vid_timing_gen_chk #(
  .FULL_CLKS(FULL_CLKS), .QTR_CLKS(QTR_CLKS), .FRAME_LINES(FRAME_LINES),
  .HW(HW), .VW(VW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .tmg_restart(tmg_restart),
  .hcnt(hcnt_o), .vcnt(vcnt_o), .strobe_raw(strobe_raw), .frame_wrap(frame_wrap),
  .shadow_load(shadow_load), .sh_cfg(sh_cfg), .cfg_in(cfg_in)
);

// File: tb/vid_timing_gen_tb_top.sv
module vid_timing_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int FULL  = 200;
  localparam int QTR   = 100;
  localparam int FRAME = 160;
  localparam int HW    = $clog2(FULL);
  localparam int VW    = $clog2(FRAME);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_en = 1'b0, tmg_restart = 1'b0, qtr_mode = 1'b0;
  logic [7:0] win_hstart = 8'd0, win_hwidth = 8'd0, win_vstart = 8'd0, win_vlines = 8'd0;
  logic pol_vd = 1'b0, pol_avf = 1'b0, pol_avh = 1'b0;
  logic vd_o, avf_o, avh_o;
  logic [HW-1:0] hcnt_o;
  logic [VW-1:0] vcnt_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_timing_gen #(.FULL_CLKS(FULL), .QTR_CLKS(QTR), .FRAME_LINES(FRAME)) dut_i (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .tmg_restart(tmg_restart),
    .qtr_mode(qtr_mode), .win_hstart(win_hstart), .win_hwidth(win_hwidth),
    .win_vstart(win_vstart), .win_vlines(win_vlines),
    .pol_vd(pol_vd), .pol_avf(pol_avf), .pol_avh(pol_avh),
    .vd_o(vd_o), .avf_o(avf_o), .avh_o(avh_o), .hcnt_o(hcnt_o), .vcnt_o(vcnt_o)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // ---------------- reference model and scoreboard ----------------
  typedef struct { int h; int v; bit vd; bit avf; bit avh; } exp_t;
  exp_t sb_q[$];

  int m_h, m_v, m_hs, m_hw, m_vs, m_vl;
  bit m_q;

  task automatic m_load();
    m_q = qtr_mode; m_hs = win_hstart; m_hw = win_hwidth;
    m_vs = win_vstart; m_vl = win_vlines;
  endtask

  always @(posedge clk) begin
    exp_t e;
    int rows, cols, llen;
    if (!rst_n) begin
      m_h = 0; m_v = 0; m_q = 0; m_hs = 14; m_hw = 176; m_vs = 8; m_vl = 160;
    end else if (tmg_restart) begin
      m_h = 0; m_v = 0; m_load();
    end else if (pix_en) begin
      llen = m_q ? QTR : FULL;
      if (m_h + 1 == llen) begin
        m_h = 0;
        if (m_v + 1 == FRAME) begin m_v = 0; m_load(); end
        else m_v = m_v + 1;
      end else m_h = m_h + 1;
    end
    rows  = m_q ? (m_vl + 128) / 2 : m_vl + 128;
    cols  = m_q ? m_hw * 2 : m_hw * 4;
    e.h   = m_h;
    e.v   = m_v;
    e.vd  = (m_v == 0);
    e.avf = (m_v >= m_vs) && (m_v - m_vs < rows);
    e.avh = e.avf && (m_h >= m_hs) && (m_h - m_hs < cols);
    sb_q.push_back(e);
  end

  // directed counters fed by the monitor
  int sel_line = 0, cnt_avh = 0, cnt_rows = 0;

  always @(negedge clk) begin
    exp_t e;
    bit a_vd, a_avf, a_avh;
    if (!done && sb_q.size() > 0) begin
      e = sb_q.pop_front();
      a_vd  = vd_o ^ pol_vd;
      a_avf = avf_o ^ pol_avf;
      a_avh = avh_o ^ pol_avh;
      check("R2 hcnt", int'(hcnt_o), e.h);
      check("R2 vcnt", int'(vcnt_o), e.v);
      check("R6 frame sync", int'(a_vd), int'(e.vd));
      check("R4 frame window", int'(a_avf), int'(e.avf));
      check("R5 line window", int'(a_avh), int'(e.avh));
      if (pix_en && a_avh && int'(vcnt_o) == sel_line) cnt_avh++;
      if (pix_en && a_avf && hcnt_o == '0) cnt_rows++;
    end
  end

  // ---------------- driver ----------------
  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic set_cfg(input bit q, input int hs, input int hw, input int vs, input int vl);
    qtr_mode = q; win_hstart = 8'(hs); win_hwidth = 8'(hw);
    win_vstart = 8'(vs); win_vlines = 8'(vl);
  endtask

  task automatic wait_pos(input int v, input int h);
    do @(negedge clk); while (!(int'(vcnt_o) == v && int'(hcnt_o) == h));
    @(posedge clk); #1;
  endtask

  initial begin
    int hold_h, hold_v;
    set_cfg(1'b0, 10, 20, 4, 0);          // A: 80 clocks from 10, 128 lines from 4
    step(3);
    @(negedge clk);
    // R1: reset state (frame sync active on line 0)
    check("R1 hcnt reset", int'(hcnt_o), 0);
    check("R1 vcnt reset", int'(vcnt_o), 0);
    check("R1 vd reset", int'(vd_o), 1);
    check("R1 avf reset", int'(avf_o), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    step(1);
    pix_en = 1'b1;
    // frame 1 runs on the defaults (R1): window clipped to 14..199, lines 8..159
    sel_line = 9; cnt_avh = 0; cnt_rows = 0;
    wait_pos(FRAME-1, FULL-1);
    check("R1 R8 default clipped width", cnt_avh, FULL - 14);
    check("R1 R8 default clipped rows", cnt_rows, FRAME - 8);
    // frame 2 on A; B applied mid frame must not act (R9)
    sel_line = 10; cnt_avh = 0; cnt_rows = 0;
    wait_pos(100, 0);
    set_cfg(1'b1, 30, 50, 100, 80);       // B: quarter, clipped both ways
    wait_pos(FRAME-1, FULL-1);
    check("R5 R9 width full mode", cnt_avh, 80);
    check("R4 R9 rows full mode", cnt_rows, 128);
    // frame 3 on B (quarter)
    sel_line = 120; cnt_avh = 0; cnt_rows = 0;
    @(negedge clk);
    check("R6 vd at frame start", int'(vd_o), 1);
    check("R2 quarter wraps", int'(hcnt_o), 0);
    wait_pos(1, 0);
    @(negedge clk);
    check("R6 vd off line1", int'(vd_o), 0);
    wait_pos(FRAME-1, QTR-1);
    check("R8 R5 width clipped quarter", cnt_avh, 70);
    check("R8 R4 rows clipped quarter", cnt_rows, 60);
    // frame 4: polarity flip acts at once (R7)
    wait_pos(5, 0);
    pol_vd = 1'b1; pol_avf = 1'b1; pol_avh = 1'b1;
    @(negedge clk);
    check("R7 vd active-low idle", int'(vd_o), 1);
    check("R7 avf active-low idle", int'(avf_o), 1);
    check("R7 avh active-low idle", int'(avh_o), 1);
    @(posedge clk); #1;
    pol_vd = 1'b0; pol_avf = 1'b0; pol_avh = 1'b0;
    // restart with new config, pix_en high (R3)
    set_cfg(1'b0, 0, 0, 0, 255);
    tmg_restart = 1'b1;
    step(1);
    tmg_restart = 1'b0;
    @(negedge clk);
    check("R3 restart hcnt", int'(hcnt_o), 0);
    check("R3 restart vcnt", int'(vcnt_o), 0);
    check("R3 R4 new rows from 0", int'(avf_o), 1);
    check("R3 R5 zero width", int'(avh_o), 0);
    // gapped enable
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1; pix_en = (i % 3 != 2);
    end
    // hold with enable low (R2)
    pix_en = 1'b0;
    step(1);
    @(negedge clk);
    hold_h = int'(hcnt_o); hold_v = int'(vcnt_o);
    step(6);
    @(negedge clk);
    check("R2 hold hcnt", int'(hcnt_o), hold_h);
    check("R2 hold vcnt", int'(vcnt_o), hold_v);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule